// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit-side engine of a network controller. Software prepares a ring of 8-byte buffer descriptors in memory and then writes the activate command. If the controller is enabled, the engine fetches descriptors one after another. For each descriptor that software has marked ready, it streams the referenced buffer bytes out toward the line side. It hands ownership back by rewriting the descriptor with its ready flag cleared, then steps to the next entry. It stops at the first descriptor that is not ready and keeps that position for the next activation.

One frame may be spread over several chained descriptors. The engine counts the bytes of the current frame and closes the frame at a descriptor whose last-in-frame flag is set. A frame never exceeds a fixed maximum size: bytes past the limit are dropped and a babble event is raised. Each descriptor processed raises a buffer event, and each completed frame also raises a frame event. All memory traffic uses a 32-bit word port with a request/grant handshake. The engine reports busy for as long as a walk is running.

Top module: `tx_bd_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `frm_valid`, `frm_done` and all three event outputs are low.
- R2: A configuration write with `cfg_sel`=2 (activate) starts a walk only when bit 1 of the last value written with `cfg_sel`=0 (control) is 1. Otherwise it has no effect: no memory request is made and `busy` stays low. `cfg_sel`=3 writes nothing.
- R3: A write with `cfg_sel`=1 stores the ring start address with bits [1:0] forced to zero. It also sets the current descriptor address, so the next walk fetches its first descriptor word from that address.
- R4: A descriptor has two parts. Its first word (at the descriptor address) holds flags in bits [31:16] and length in bits [15:0]. Its second word (address + 4) holds the byte address of the buffer. Flag bit 15 (word bit 31) means ready. A walk ends at the first descriptor read whose ready bit is 0. The next activation fetches from that same descriptor address.
- R5: Buffer bytes leave on `frm_byte` one per `frm_valid` cycle, in increasing address order, from any start alignment. Within a memory word, the byte at the lowest address is bits [31:24].
- R6: After its bytes are sent, a ready descriptor's first word is written back to the same address. Flag bit 15 is cleared and all other flag bits and the length are unchanged. The second word is not written.
- R7: After a descriptor is processed, the next descriptor address is the ring start address if flag bit 13 (wrap) is set, and the current address plus 8 otherwise.
- R8: Bytes of consecutive descriptors accumulate into one frame. A descriptor with flag bit 11 (last) pulses `frm_done` for one cycle with `frm_len` equal to the frame's byte count, and the next frame counts from zero.
- R9: A frame carries at most MAX_FRAME (2032) bytes. If a descriptor's length would take the frame past that limit, only the bytes up to the limit are sent, the rest of that buffer is skipped, and `evt_babt` pulses once.
- R10: Every processed ready descriptor pulses `evt_txb` once. A processed descriptor with the last flag also pulses `evt_txf` in the same cycle.
- R11: `busy` is high from the cycle after an accepted activation until the walk ends. While it is low, neither `mem_req` nor `frm_valid` is asserted.
- R12: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until a cycle with `mem_gnt` high. Read data is taken from `mem_rdata` in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 control, 1 ring start, 2 activate, 3 unused |
| cfg_wdata | input | 32 | Configuration write value |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word (bits [1:0] zero for data fetches) |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| frm_valid | output | 1 | `frm_byte` carries a frame byte |
| frm_byte | output | 8 | Frame data byte |
| frm_done | output | 1 | Frame completed (one cycle) |
| frm_len | output | 11 | Byte count of the completed frame |
| evt_txb | output | 1 | Descriptor processed pulse |
| evt_txf | output | 1 | Frame completed pulse |
| evt_babt | output | 1 | Frame truncated pulse |

## Verification
The assertions run on every cycle. They check that a pending memory request holds its address and direction until it is granted, that no request or byte appears while the engine is idle, that a frame event never comes without a buffer event, and that no reported frame length exceeds the limit. Other behaviours can only be seen across a whole walk, so the bench's scenarios cover them. These are: the order and alignment of bytes, the exact writeback word and its address, the return to the ring start on wrap, resuming at the stalled descriptor, enable gating, and truncation at 2032 bytes with the count restarting for the next frame.

// File: rtl/txw_pkg.sv
package txw_pkg;

    // Descriptor flag bit positions inside the 16-bit flag half-word
    localparam int FLG_READY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;

    // Control register enable bit
    localparam int CTRL_EN_BIT = 1;

    // Step between consecutive descriptors and to the pointer word
    localparam logic [31:0] BD_STRIDE   = 32'd8;
    localparam logic [31:0] BD_PTR_OFFS = 32'd4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_RING = 2'd1,
        SEL_GO   = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BD0,
        ST_BD1,
        ST_FETCH,
        ST_EMIT,
        ST_WBACK
    } walk_st_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
        logic [31:0] ptr;
    } bd_t;

    // Big-endian byte lane pick: offset 0 is the most significant byte
    function automatic logic [7:0] be_lane(input logic [31:0] w, input logic [1:0] idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = w[31:24];
            2'd1:    b = w[23:16];
            2'd2:    b = w[15:8];
            default: b = w[7:0];
        endcase
        return b;
    endfunction

    // Flag half-word as handed back to software
    function automatic logic [15:0] release_flags(input logic [15:0] f);
        logic [15:0] r;
        r = f;
        r[FLG_READY] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txw_cfg.sv
module txw_cfg
    import txw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        go,
    output logic        ring_wr,
    output logic [31:0] ring_next,
    output logic [31:0] ring_base
);

    logic en_q;
    logic unused_bit0;

    assign unused_bit0 = cfg_wdata[0];
    assign ring_next   = {cfg_wdata[31:2], 2'b00};
    assign ring_wr     = cfg_we && (cfg_sel == SEL_RING);
    assign go          = cfg_we && (cfg_sel == SEL_GO) && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            ring_base <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL: en_q      <= cfg_wdata[CTRL_EN_BIT];
                SEL_RING: ring_base <= ring_next;
                default:  ;
            endcase
        end
    end

    // Ring start never holds a misaligned address (R3)
    p_ring_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        $past(ring_wr) |-> ring_base[1:0] == 2'b00);

endmodule

// File: rtl/txw_limit.sv
module txw_limit #(
    parameter int MAX_FRAME = 2032,
    parameter int ACC_W     = 11
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [15:0]      len,
    output logic [15:0]      take,
    output logic             over
);

    localparam logic [ACC_W-1:0] MAXV = ACC_W'(MAX_FRAME);

    logic [15:0] room;

    always_comb begin
        room = 16'(MAXV - acc);
        over = (len > room);
        take = over ? room : len;
    end

endmodule

// File: rtl/txw_walker.sv
module txw_walker
    import txw_pkg::*;
#(
    parameter int MAX_FRAME = 2032,
    parameter int ACC_W     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             ring_wr,
    input  logic [31:0]      ring_next,
    input  logic [31:0]      ring_base,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    output logic             frm_valid,
    output logic [7:0]       frm_byte,
    output logic             frm_done,
    output logic [ACC_W-1:0] frm_len,
    output logic             evt_txb,
    output logic             evt_txf,
    output logic             evt_babt
);

    walk_st_e         st;
    bd_t              bd;
    logic [31:0]      cur;
    logic [15:0]      rem;
    logic [ACC_W-1:0] acc;
    logic [31:0]      word_q;
    logic [15:0]      take;
    logic             over;

    txw_limit #(.MAX_FRAME(MAX_FRAME), .ACC_W(ACC_W)) u_limit (
        .acc  (acc),
        .len  (bd.len),
        .take (take),
        .over (over)
    );

    // Memory-side and stream-side outputs decoded from state
    always_comb begin
        busy      = (st != ST_IDLE);
        mem_req   = (st == ST_BD0) || (st == ST_BD1) || (st == ST_FETCH) || (st == ST_WBACK);
        mem_we    = (st == ST_WBACK);
        mem_wdata = {release_flags(bd.flags), bd.len};
        case (st)
            ST_BD1:   mem_addr = cur + BD_PTR_OFFS;
            ST_FETCH: mem_addr = {bd.ptr[31:2], 2'b00};
            default:  mem_addr = cur;
        endcase
        frm_valid = (st == ST_EMIT);
        frm_byte  = be_lane(word_q, bd.ptr[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bd       <= '0;
            cur      <= '0;
            rem      <= '0;
            acc      <= '0;
            word_q   <= '0;
            frm_done <= 1'b0;
            frm_len  <= '0;
            evt_txb  <= 1'b0;
            evt_txf  <= 1'b0;
            evt_babt <= 1'b0;
        end else begin
            frm_done <= 1'b0;
            evt_txb  <= 1'b0;
            evt_txf  <= 1'b0;
            evt_babt <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go) st <= ST_BD0;
                end
                ST_BD0: begin
                    if (mem_gnt) begin
                        bd.flags <= mem_rdata[31:16];
                        bd.len   <= mem_rdata[15:0];
                        st       <= mem_rdata[16+FLG_READY] ? ST_BD1 : ST_IDLE;
                    end
                end
                ST_BD1: begin
                    if (mem_gnt) begin
                        bd.ptr   <= mem_rdata;
                        rem      <= take;
                        evt_babt <= over;
                        st       <= (take == 16'd0) ? ST_WBACK : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_gnt) begin
                        word_q <= mem_rdata;
                        st     <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    bd.ptr <= bd.ptr + 32'd1;
                    rem    <= rem - 16'd1;
                    acc    <= acc + ACC_W'(1);
                    if (rem == 16'd1)
                        st <= ST_WBACK;
                    else if (bd.ptr[1:0] == 2'b11)
                        st <= ST_FETCH;
                end
                ST_WBACK: begin
                    if (mem_gnt) begin
                        evt_txb <= 1'b1;
                        if (bd.flags[FLG_LAST]) begin
                            evt_txf  <= 1'b1;
                            frm_done <= 1'b1;
                            frm_len  <= acc;
                            acc      <= '0;
                        end
                        cur <= bd.flags[FLG_WRAP] ? ring_base : cur + BD_STRIDE;
                        st  <= ST_BD0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
            if (ring_wr) cur <= ring_next;
        end
    end

    // R12: an ungranted request is held unchanged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: nothing moves while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !frm_valid));

    // R10: a frame event always comes with a buffer event
    p_txf_with_txb_r10: assert property (@(posedge clk) disable iff (rst)
        evt_txf |-> evt_txb);

    // R9: reported frame length never exceeds the limit
    p_len_cap_r9: assert property (@(posedge clk) disable iff (rst)
        frm_done |-> (frm_len <= ACC_W'(MAX_FRAME)));

    // R9: the accumulator never runs past the limit
    p_acc_cap_r9: assert property (@(posedge clk) disable iff (rst)
        acc <= ACC_W'(MAX_FRAME));

endmodule

// File: rtl/tx_bd_walker.sv
module tx_bd_walker
    import txw_pkg::*;
#(
    parameter int MAX_FRAME = 2032,
    localparam int ACC_W    = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    output logic             frm_valid,
    output logic [7:0]       frm_byte,
    output logic             frm_done,
    output logic [ACC_W-1:0] frm_len,
    output logic             evt_txb,
    output logic             evt_txf,
    output logic             evt_babt
);

    logic        go;
    logic        ring_wr;
    logic [31:0] ring_next;
    logic [31:0] ring_base;

    txw_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .go        (go),
        .ring_wr   (ring_wr),
        .ring_next (ring_next),
        .ring_base (ring_base)
    );

    txw_walker #(.MAX_FRAME(MAX_FRAME), .ACC_W(ACC_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .ring_wr   (ring_wr),
        .ring_next (ring_next),
        .ring_base (ring_base),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .frm_valid (frm_valid),
        .frm_byte  (frm_byte),
        .frm_done  (frm_done),
        .frm_len   (frm_len),
        .evt_txb   (evt_txb),
        .evt_txf   (evt_txf),
        .evt_babt  (evt_babt)
    );

endmodule

// File: tb/tx_bd_walker_test.sv
module tx_bd_walker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [31:0] cfg_wdata = '0;
    logic        busy, mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        frm_valid, frm_done, evt_txb, evt_txf, evt_babt;
    logic [7:0]  frm_byte;
    logic [10:0] frm_len;

    always #5 clk = ~clk;

    tx_bd_walker uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .frm_valid(frm_valid), .frm_byte(frm_byte), .frm_done(frm_done), .frm_len(frm_len),
        .evt_txb(evt_txb), .evt_txf(evt_txf), .evt_babt(evt_babt)
    );

    // Memory model: 4 KiB, grant on alternate cycles
    logic [31:0] mem [0:1023];
    logic        gnt_en = 1'b0;
    assign mem_gnt   = mem_req && gnt_en;
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        gnt_en <= ~gnt_en;
        if (mem_req && mem_gnt && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 3) + (a >> 8) + 8'h5A);
    endfunction

    // Observation state
    logic [7:0]  got_q [$];
    logic [31:0] rd_q  [$];
    logic [31:0] wra_q [$];
    logic [31:0] wrd_q [$];
    int          len_q [$];
    int          txb_n, txf_n, babt_n, hold_bad, idle_bad;
    logic        pend_q = 1'b0;
    logic [31:0] pend_a;
    logic        pend_we;

    always @(negedge clk) begin
        if (!rst) begin
            if (frm_valid) got_q.push_back(frm_byte);
            if (frm_done)  len_q.push_back(int'(frm_len));
            if (evt_txb)   txb_n++;
            if (evt_txf)   txf_n++;
            if (evt_babt)  babt_n++;
            if (!busy && (mem_req || frm_valid)) idle_bad++;
            if (pend_q && (!mem_req || mem_addr != pend_a || mem_we != pend_we)) hold_bad++;
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    wra_q.push_back(mem_addr);
                    wrd_q.push_back(mem_wdata);
                end else begin
                    rd_q.push_back(mem_addr);
                end
            end
            pend_q  <= mem_req && !mem_gnt;
            pend_a  <= mem_addr;
            pend_we <= mem_we;
        end
    end

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        got_q.delete(); rd_q.delete(); wra_q.delete(); wrd_q.delete(); len_q.delete();
        txb_n = 0; txf_n = 0; babt_n = 0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic put_bd(input int a, input logic [15:0] f, input logic [15:0] l, input logic [31:0] p);
        mem[a >> 2]       = {f, l};
        mem[(a >> 2) + 1] = p;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !mem_req && !frm_valid && !frm_done, "R1 idle after reset",
            {28'd0, busy, mem_req, frm_valid, frm_done}, 32'd0);
        chk(!evt_txb && !evt_txf && !evt_babt, "R1 events low", {29'd0, evt_txb, evt_txf, evt_babt}, 32'd0);
    endtask

    task automatic t_disabled();
        bit saw_busy = 0;
        clear_obs();
        put_bd(32'h100, 16'h8800, 16'd1, 32'h500);
        cfg_write(2'd1, 32'h100);
        cfg_write(2'd2, 32'h0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (busy) saw_busy = 1;
        end
        chk(rd_q.size() == 0, "R2 no fetch while disabled", rd_q.size(), 0);
        chk(!saw_busy, "R2 busy stays low while disabled", {31'd0, saw_busy}, 0);
    endtask

    task automatic t_single();
        bit ok = 1;
        clear_obs();
        put_bd(32'h100, 16'h8800, 16'd5, 32'h402);
        put_bd(32'h108, 16'h0000, 16'd0, 32'h0);
        cfg_write(2'd0, 32'h2);
        cfg_write(2'd1, 32'h103);
        cfg_write(2'd2, 32'h0);
        chk(busy, "R11 busy after activation", {31'd0, busy}, 1);
        wait_idle();
        chk(rd_q.size() > 0 && rd_q[0] == 32'h100, "R3 first fetch at masked ring start",
            rd_q.size() > 0 ? rd_q[0] : 32'hFFFF_FFFF, 32'h100);
        chk(got_q.size() == 5, "R5 byte count", got_q.size(), 5);
        for (int i = 0; i < 5 && i < got_q.size(); i++)
            if (got_q[i] != pat(32'h402 + i)) ok = 0;
        chk(ok, "R5 unaligned big-endian bytes", got_q.size() > 0 ? got_q[0] : 0, pat(32'h402));
        chk(wra_q.size() == 1 && wra_q[0] == 32'h100 && wrd_q[0] == 32'h0800_0005,
            "R6 writeback word", wrd_q.size() > 0 ? wrd_q[0] : 0, 32'h0800_0005);
        chk(len_q.size() == 1 && len_q[0] == 5, "R8 frame length", len_q.size() > 0 ? len_q[0] : -1, 5);
        chk(txb_n == 1 && txf_n == 1 && babt_n == 0, "R10 event counts", {txb_n[7:0], txf_n[7:0], babt_n[7:0]}, 32'h010100);
        chk(rd_q.size() > 0 && rd_q[rd_q.size()-1] == 32'h108, "R4 stop at not-ready descriptor",
            rd_q.size() > 0 ? rd_q[rd_q.size()-1] : 0, 32'h108);
        // Resume at the stalled descriptor
        clear_obs();
        put_bd(32'h108, 16'h8800, 16'd1, 32'h500);
        put_bd(32'h110, 16'h0000, 16'd0, 32'h0);
        cfg_write(2'd2, 32'h0);
        wait_idle();
        chk(rd_q.size() > 0 && rd_q[0] == 32'h108, "R4 resume at kept address",
            rd_q.size() > 0 ? rd_q[0] : 0, 32'h108);
        chk(got_q.size() == 1 && got_q[0] == pat(32'h500), "R5 single byte",
            got_q.size() > 0 ? got_q[0] : 0, pat(32'h500));
    endtask

    task automatic t_chain();
        bit ok = 1;
        clear_obs();
        put_bd(32'h200, 16'h8000, 16'd3, 32'h601);
        put_bd(32'h208, 16'hA800, 16'd4, 32'h6FE);
        cfg_write(2'd1, 32'h200);
        cfg_write(2'd2, 32'h0);
        wait_idle();
        chk(len_q.size() == 1 && len_q[0] == 7, "R8 chained frame length", len_q.size() > 0 ? len_q[0] : -1, 7);
        chk(got_q.size() == 7, "R8 chained byte count", got_q.size(), 7);
        for (int i = 0; i < 3 && i < got_q.size(); i++) if (got_q[i] != pat(32'h601 + i)) ok = 0;
        for (int i = 0; i < 4 && i + 3 < got_q.size(); i++) if (got_q[i+3] != pat(32'h6FE + i)) ok = 0;
        chk(ok, "R5 chained byte order across words", got_q.size() > 3 ? got_q[3] : 0, pat(32'h6FE));
        chk(txb_n == 2 && txf_n == 1, "R10 chained event counts", {txb_n[15:0], txf_n[15:0]}, 32'h0002_0001);
        chk(wra_q.size() == 2 && wrd_q[0] == 32'h0000_0003 && wrd_q[1] == 32'h2800_0004,
            "R6 writeback keeps other flags", wrd_q.size() > 1 ? wrd_q[1] : 0, 32'h2800_0004);
        chk(rd_q.size() > 0 && rd_q[rd_q.size()-1] == 32'h200, "R7 wrap returns to ring start",
            rd_q.size() > 0 ? rd_q[rd_q.size()-1] : 0, 32'h200);
        chk(rd_q.size() > 2 && rd_q[2] == 32'h600 && rd_q[1] == 32'h204, "R7 pointer word at +4",
            rd_q.size() > 1 ? rd_q[1] : 0, 32'h204);
    endtask

    task automatic t_babble();
        bit ok = 1;
        clear_obs();
        put_bd(32'h300, 16'h8000, 16'd2000, 32'h800);
        put_bd(32'h308, 16'h8800, 16'd100,  32'h400);
        put_bd(32'h310, 16'h8800, 16'd4,    32'h480);
        put_bd(32'h318, 16'h0000, 16'd0,    32'h0);
        cfg_write(2'd1, 32'h300);
        cfg_write(2'd2, 32'h0);
        wait_idle();
        chk(got_q.size() == 2036, "R9 truncated byte total", got_q.size(), 2036);
        chk(len_q.size() == 2 && len_q[0] == 2032, "R9 frame capped at 2032",
            len_q.size() > 0 ? len_q[0] : -1, 2032);
        chk(len_q.size() == 2 && len_q[1] == 4, "R8 count restarts after frame",
            len_q.size() > 1 ? len_q[1] : -1, 4);
        chk(babt_n == 1, "R9 babble event once", babt_n, 1);
        if (got_q.size() == 2036) begin
            for (int i = 0; i < 2000; i++) if (got_q[i] != pat(32'h800 + i)) ok = 0;
            for (int i = 0; i < 32; i++)   if (got_q[2000+i] != pat(32'h400 + i)) ok = 0;
            for (int i = 0; i < 4; i++)    if (got_q[2032+i] != pat(32'h480 + i)) ok = 0;
        end else ok = 0;
        chk(ok, "R9 kept bytes are the leading ones", got_q.size() > 2032 ? got_q[2032] : 0, pat(32'h480));
        chk(txb_n == 3 && txf_n == 2, "R10 events with truncation", {txb_n[15:0], txf_n[15:0]}, 32'h0003_0002);
        chk(hold_bad == 0, "R12 request held until grant", hold_bad, 0);
        chk(idle_bad == 0, "R11 quiet while idle", idle_bad, 0);
    endtask

    initial begin
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(4*w), pat(4*w+1), pat(4*w+2), pat(4*w+3)};
        txb_n = 0; txf_n = 0; babt_n = 0; hold_bad = 0; idle_bad = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_single();
        t_chain();
        t_babble();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule